// File: doc/BRIEF.md
# Wake-on-LAN Event Detector

This block sits beside a receive path and watches every frame as it streams past, one byte per beat. When a frame ends, it decides whether one of four wake conditions was met: a magic packet carrying the station's own MAC address, an ARP request for the station's IP address, a hit in the specific-address-1 filter, or a hit in the multicast hash filter. When a condition is met and its own enable bit is set, a single-bit wake output is driven high for a fixed number of receive clocks. The length is 64 by default.

The address filter and the hash filter are outside this block. Their verdicts, together with the end-of-frame error flag, arrive on the beat that carries the last byte of the frame. A hit in either filter, or a recognised ARP request, wakes the station even if the frame is errored. A magic packet wakes it only if the frame is error free and its destination matched address 1. The enables and the receive enable are sampled on that same final beat. Whether a receive buffer is free plays no part in the decision.

Internally, a magic-packet scanner is built around the states `MG_SYNC`, `MG_MAC` and `MG_FOUND`:
- `MG_SYNC` counts consecutive 0xFF bytes. Once at least six have been seen, the first byte that is not 0xFF and equals the first MAC byte moves the scanner to `MG_MAC`.
- `MG_MAC` steps through the MAC byte by byte, 16 times over.
  - A mismatch returns to `MG_SYNC`. The run count restarts at 1 if the offending byte is 0xFF and at 0 otherwise.
  - Completing the 16th copy moves to `MG_FOUND`, which holds until the next start of frame.
- A start-of-frame beat is handled as if the scanner were in `MG_SYNC` with empty counters.

A pulse stretcher has two states, `PL_IDLE` and `PL_HOLD`:
- A fire moves `PL_IDLE` to `PL_HOLD`.
- In `PL_HOLD`, the counter counts down. It returns to `PL_IDLE` when the count is exhausted, and a fresh fire reloads the counter.

Top module: `wol_detect`

## Requirements
- R1: After reset, and whenever no enabled event has occurred in the last 64 cycles, `wake` is low.
- R2: An event is evaluated only on a beat with `rx_valid` and `rx_eof` both high. `wake` goes high in the cycle after that beat and stays high for exactly 64 cycles.
- R3: An event that occurs while `wake` is high restarts the count, so `wake` stays high for exactly 64 cycles after the later end-of-frame beat.
- R4: When `rx_en` is low on the end-of-frame beat, no event fires, whatever the filter results and enables.
- R5: The enable bits are mapped as follows, and an event whose bit is clear never fires: `ev_en[0]` magic packet, `ev_en[1]` ARP request, `ev_en[2]` address-1 hit, `ev_en[3]` hash hit.
- R6: The address-1 and hash events fire when `addr1_hit` or `hash_hit` is high on the end-of-frame beat, even with `rx_err` high.
- R7: An ARP request event needs all of the following, and it fires even with `rx_err` high:
  - bytes 12 and 13 equal to 0x08 and 0x06;
  - bytes 20 and 21 equal to 0x00 and 0x01;
  - bytes 38 to 41 equal to `dev_ip`, most significant byte first.
- R8: A magic packet needs a run of at least six 0xFF bytes, followed at once by 16 back-to-back copies of `dev_mac`, each sent as `dev_mac[47:40]` first. The sequence must end within the frame. A run of five 0xFF bytes is not enough.
- R9: A magic packet event also needs `rx_err` low and `addr1_hit` high on the end-of-frame beat.
- R10: A byte that breaks the MAC copies restarts the search for a 0xFF run. A complete sequence later in the same frame still counts.
- R11: Beats with `rx_eof` low, and any cycle with `rx_valid` low, never start a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | A byte is present this cycle |
| rx_sof | input | 1 | The byte is the first of a frame |
| rx_eof | input | 1 | The byte is the last of a frame |
| rx_data | input | 8 | Received byte |
| rx_err | input | 1 | Frame error flag, valid on the last beat |
| addr1_hit | input | 1 | Destination matched specific address 1, valid on the last beat |
| hash_hit | input | 1 | Multicast hash filter hit, valid on the last beat |
| dev_mac | input | 48 | Station MAC address |
| dev_ip | input | 32 | Station IP address |
| ev_en | input | 4 | Per-event enables (see R5) |
| rx_en | input | 1 | Receive enable |
| wake | output | 1 | Stretched wake pulse |

## Verification
Every result becomes visible on `wake` one clock after the end-of-frame beat: one register stage in the stretcher, fed by combinational scanner outputs that include the final byte. The bench drives each byte on a falling edge and reads `wake` on the falling edge right after the final beat. From there it counts high samples one falling edge at a time until the pulse ends, and expects exactly 64. For frames that must not wake the station, it watches the full window and checks that `wake` stays low. In the restart case, the count begins at the later end-of-frame beat.

// File: rtl/wol_pkg.sv
package wol_pkg;

    typedef enum logic [1:0] {
        MG_SYNC  = 2'd0,
        MG_MAC   = 2'd1,
        MG_FOUND = 2'd2
    } mg_state_t;

    typedef enum logic {
        PL_IDLE = 1'b0,
        PL_HOLD = 1'b1
    } pl_state_t;

    localparam int EV_MAGIC = 0;
    localparam int EV_ARP   = 1;
    localparam int EV_ADDR1 = 2;
    localparam int EV_HASH  = 3;
    localparam int EV_COUNT = 4;

endpackage

// File: rtl/wol_magic_scan.sv
module wol_magic_scan
    import wol_pkg::*;
#(
    parameter int SYNC_MIN = 6,
    parameter int REPEATS  = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        beat,
    input  logic        sof,
    input  logic [7:0]  data,
    input  logic [47:0] mac,
    output logic        hit
);
    localparam int SW = $clog2(SYNC_MIN + 1);
    localparam int RW = (REPEATS > 1) ? $clog2(REPEATS) : 1;

    mg_state_t      st_q, st_c, st_n;
    logic [SW-1:0]  ff_q, ff_c, ff_n;
    logic [2:0]     pos_q, pos_c, pos_n;
    logic [RW-1:0]  rep_q, rep_c, rep_n;
    logic [7:0]     want;
    logic           same;

    function automatic logic [7:0] mac_byte(input logic [47:0] m, input logic [2:0] p);
        case (p)
            3'd0:    return m[47:40];
            3'd1:    return m[39:32];
            3'd2:    return m[31:24];
            3'd3:    return m[23:16];
            3'd4:    return m[15:8];
            default: return m[7:0];
        endcase
    endfunction

    // A start of frame overrides the held scan state.
    always_comb begin
        st_c  = sof ? MG_SYNC : st_q;
        ff_c  = sof ? '0 : ff_q;
        pos_c = sof ? '0 : pos_q;
        rep_c = sof ? '0 : rep_q;
        want  = mac_byte(mac, pos_c);
        same  = (data == want);
    end

    always_comb begin
        st_n  = st_c;
        ff_n  = ff_c;
        pos_n = pos_c;
        rep_n = rep_c;
        unique case (st_c)
            MG_SYNC: begin
                if (data == 8'hFF) begin
                    ff_n = (ff_c == SW'(SYNC_MIN)) ? ff_c : ff_c + 1'b1;
                end else if (ff_c == SW'(SYNC_MIN) && same) begin
                    st_n  = MG_MAC;
                    pos_n = 3'd1;
                    rep_n = '0;
                end else begin
                    ff_n = '0;
                end
            end
            MG_MAC: begin
                if (same) begin
                    if (pos_c == 3'd5) begin
                        pos_n = '0;
                        if (rep_c == RW'(REPEATS - 1)) st_n = MG_FOUND;
                        else                           rep_n = rep_c + 1'b1;
                    end else begin
                        pos_n = pos_c + 1'b1;
                    end
                end else begin
                    st_n  = MG_SYNC;
                    pos_n = '0;
                    ff_n  = (data == 8'hFF) ? SW'(1) : '0;
                end
            end
            default: begin
                st_n = MG_FOUND;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= MG_SYNC;
            ff_q  <= '0;
            pos_q <= '0;
            rep_q <= '0;
        end else if (beat) begin
            st_q  <= st_n;
            ff_q  <= ff_n;
            pos_q <= pos_n;
            rep_q <= rep_n;
        end
    end

    // Includes the byte on the current beat, so a frame may end on the last MAC byte.
    assign hit = beat && ((st_c == MG_FOUND) ||
                 (st_c == MG_MAC && same && pos_c == 3'd5 && rep_c == RW'(REPEATS - 1)));

endmodule

// File: rtl/wol_arp_scan.sv
module wol_arp_scan #(
    parameter int LAST_IDX = 41
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        beat,
    input  logic        sof,
    input  logic [7:0]  data,
    input  logic [31:0] ip,
    output logic        hit
);
    localparam int IW = $clog2(LAST_IDX + 2);

    logic [IW-1:0] idx_q, idx_c;
    logic          good_q, good_c, byte_ok;

    always_comb begin
        idx_c  = sof ? '0 : idx_q;
        good_c = sof ? 1'b1 : good_q;
        case (int'(idx_c))
            12:      byte_ok = (data == 8'h08);
            13:      byte_ok = (data == 8'h06);
            20:      byte_ok = (data == 8'h00);
            21:      byte_ok = (data == 8'h01);
            38:      byte_ok = (data == ip[31:24]);
            39:      byte_ok = (data == ip[23:16]);
            40:      byte_ok = (data == ip[15:8]);
            41:      byte_ok = (data == ip[7:0]);
            default: byte_ok = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            good_q <= 1'b0;
        end else if (beat) begin
            good_q <= good_c && byte_ok;
            idx_q  <= (int'(idx_c) > LAST_IDX) ? idx_c : idx_c + 1'b1;
        end
    end

    assign hit = beat && good_c && byte_ok && (int'(idx_c) >= LAST_IDX);

endmodule

// File: rtl/wol_pulse.sv
module wol_pulse
    import wol_pkg::*;
#(
    parameter int LEN = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic wake
);
    localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;

    pl_state_t     st_q, st_n;
    logic [CW-1:0] cnt_q, cnt_n;

    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        unique case (st_q)
            PL_IDLE: begin
                if (fire) begin
                    st_n  = PL_HOLD;
                    cnt_n = CW'(LEN - 1);
                end
            end
            PL_HOLD: begin
                if (fire)             cnt_n = CW'(LEN - 1);
                else if (cnt_q == '0) st_n  = PL_IDLE;
                else                  cnt_n = cnt_q - 1'b1;
            end
            default: st_n = PL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= PL_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

    always_comb begin
        wake = (st_q == PL_HOLD);
    end

endmodule

// File: rtl/wol_detect.sv
module wol_detect
    import wol_pkg::*;
#(
    parameter int PULSE_LEN = 64,
    parameter int SYNC_MIN  = 6,
    parameter int REPEATS   = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic        rx_sof,
    input  logic        rx_eof,
    input  logic [7:0]  rx_data,
    input  logic        rx_err,
    input  logic        addr1_hit,
    input  logic        hash_hit,
    input  logic [47:0] dev_mac,
    input  logic [31:0] dev_ip,
    input  logic [3:0]  ev_en,
    input  logic        rx_en,
    output logic        wake
);
    logic                magic_hit, arp_hit, last_beat, fire;
    logic [EV_COUNT-1:0] ev_seen;

    wol_magic_scan #(.SYNC_MIN(SYNC_MIN), .REPEATS(REPEATS)) u_magic (
        .clk(clk), .rst_n(rst_n), .beat(rx_valid), .sof(rx_sof),
        .data(rx_data), .mac(dev_mac), .hit(magic_hit)
    );

    wol_arp_scan #(.LAST_IDX(41)) u_arp (
        .clk(clk), .rst_n(rst_n), .beat(rx_valid), .sof(rx_sof),
        .data(rx_data), .ip(dev_ip), .hit(arp_hit)
    );

    always_comb begin
        last_beat          = rx_valid && rx_eof;
        ev_seen[EV_MAGIC]  = magic_hit && !rx_err && addr1_hit;
        ev_seen[EV_ARP]    = arp_hit;
        ev_seen[EV_ADDR1]  = addr1_hit;
        ev_seen[EV_HASH]   = hash_hit;
        fire               = last_beat && rx_en && |(ev_seen & ev_en);
    end

    wol_pulse #(.LEN(PULSE_LEN)) u_pulse (
        .clk(clk), .rst_n(rst_n), .fire(fire), .wake(wake)
    );

endmodule

// File: rtl/wol_detect_chk.sv
module wol_detect_chk #(
    parameter int PULSE_LEN = 64
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic       rx_eof,
    input logic       addr1_hit,
    input logic       hash_hit,
    input logic [3:0] ev_en,
    input logic       rx_en,
    input logic       wake
);
    localparam int HW = $clog2(PULSE_LEN + 2) + 1;

    logic [HW-1:0] hi_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    hi_run <= '0;
        else if (wake) hi_run <= (hi_run == '1) ? hi_run : hi_run + 1'b1;
        else           hi_run <= '0;
    end

    p_rise_on_eof_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake) |-> $past(rx_valid && rx_eof && rx_en));

    p_rxen_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wake && rx_valid && rx_eof && !rx_en) |=> !wake);

    p_addr1_fires_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_eof && rx_en && ev_en[2] && addr1_hit) |=> wake);

    p_hash_fires_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_eof && rx_en && ev_en[3] && hash_hit) |=> wake);

    p_min_length_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wake) |-> (int'(hi_run) >= PULSE_LEN));

endmodule

bind wol_detect wol_detect_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_eof(rx_eof),
    .addr1_hit(addr1_hit), .hash_hit(hash_hit), .ev_en(ev_en),
    .rx_en(rx_en), .wake(wake)
);

// File: tb/sim_wol_detect.sv
module sim_wol_detect;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_err = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        addr1_hit = 1'b0, hash_hit = 1'b0, rx_en = 1'b0;
    logic [47:0] dev_mac;
    logic [31:0] dev_ip;
    logic [3:0]  ev_en = '0;
    logic        wake;

    int nvec = 0;
    int nerr = 0;
    logic [7:0] fr [0:255];
    int flen;

    always #4 clk = ~clk;

    wol_detect u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .rx_data(rx_data), .rx_err(rx_err), .addr1_hit(addr1_hit), .hash_hit(hash_hit),
        .dev_mac(dev_mac), .dev_ip(dev_ip), .ev_en(ev_en), .rx_en(rx_en), .wake(wake)
    );

    task automatic check(input logic got, input logic exp, input string tag);
        nvec++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic check_int(input int got, input int exp, input string tag);
        nvec++;
        if (got != exp) begin
            nerr++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] mb(input int k);
        return dev_mac[8*(5-k) +: 8];
    endfunction

    // Reference: six 0xFF bytes immediately before 96 bytes of MAC copies.
    function automatic bit ref_magic(input int len);
        for (int p = 6; p + 96 <= len; p++) begin
            bit ok = 1;
            for (int j = 1; j <= 6; j++) if (fr[p-j] != 8'hFF) ok = 0;
            for (int j = 0; j < 96; j++) if (fr[p+j] != mb(j % 6)) ok = 0;
            if (ok) return 1;
        end
        return 0;
    endfunction

    function automatic bit ref_arp(input int len);
        return len >= 42 && fr[12] == 8'h08 && fr[13] == 8'h06 && fr[20] == 8'h00 &&
               fr[21] == 8'h01 && {fr[38], fr[39], fr[40], fr[41]} == dev_ip;
    endfunction

    function automatic bit ref_event(input int len, input bit err, input bit a1,
                                     input bit hh, input bit [3:0] en, input bit ren);
        return ren && ((en[0] && ref_magic(len) && !err && a1) || (en[1] && ref_arp(len)) ||
                       (en[2] && a1) || (en[3] && hh));
    endfunction

    task automatic fill_random(input int len);
        for (int i = 0; i < len; i++) fr[i] = 8'($urandom_range(0, 254));
        fr[12] = 8'h45;
        flen = len;
    endtask

    task automatic build_magic(input int nff, input int bad_at);
        fill_random(14 + nff + 96 + 6);
        for (int i = 0; i < nff; i++) fr[14+i] = 8'hFF;
        for (int j = 0; j < 96; j++) fr[14+nff+j] = mb(j % 6);
        if (bad_at >= 0) fr[14+nff+bad_at] = fr[14+nff+bad_at] ^ 8'h01;
    endtask

    task automatic build_arp(input bit good);
        fill_random(60);
        fr[12] = 8'h08; fr[13] = 8'h06; fr[20] = 8'h00; fr[21] = 8'h01;
        {fr[38], fr[39], fr[40], fr[41]} = dev_ip;
        if (!good) fr[40] = fr[40] ^ 8'h10;
    endtask

    task automatic send(input bit err, input bit a1, input bit hh, input bit [3:0] en,
                        input bit ren, input bit gaps);
        for (int i = 0; i < flen; i++) begin
            if (gaps && $urandom_range(0, 7) == 0) begin
                @(negedge clk);
                rx_valid = 0; rx_eof = 1; rx_data = 8'h5A; addr1_hit = 1; hash_hit = 1;
                ev_en = 4'hF; rx_en = 1;
            end
            @(negedge clk);
            rx_valid = 1; rx_data = fr[i]; rx_sof = (i == 0); rx_eof = (i == flen - 1);
            rx_err = (i == flen - 1) ? err : 1'b0;
            addr1_hit = (i == flen - 1) ? a1 : 1'b0;
            hash_hit  = (i == flen - 1) ? hh : 1'b0;
            ev_en = en; rx_en = ren;
        end
        @(negedge clk);
        rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_err = 0; addr1_hit = 0; hash_hit = 0;
    endtask

    // Counts high samples from the current falling edge, then checks the run length.
    task automatic expect_pulse(input bit exp, input string tag);
        int n = 0;
        check(wake, exp, tag);
        while (wake && n < 300) begin
            n++;
            @(negedge clk);
        end
        if (exp) check_int(n, 64, {tag, " length"});
        else begin
            repeat (70) @(negedge clk);
            check(wake, 1'b0, {tag, " stays low"});
        end
    endtask

    task automatic run(input bit err, input bit a1, input bit hh, input bit [3:0] en,
                       input bit ren, input bit gaps, input string tag);
        bit e = ref_event(flen, err, a1, hh, en, ren);
        send(err, a1, hh, en, ren, gaps);
        expect_pulse(e, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        dev_mac = {8'h3C, 8'h11, 8'hA0, 8'h07, 8'hFE, 8'h52};
        dev_ip  = 32'hC0A8_0117;
        repeat (3) @(negedge clk);
        check(wake, 1'b0, "R1 in reset");
        rst_n = 1;
        repeat (3) @(negedge clk);
        check(wake, 1'b0, "R1 after reset");

        fill_random(60); run(1, 1, 0, 4'b0100, 1, 0, "R6 addr1 errored R2");
        fill_random(60); run(1, 0, 1, 4'b1000, 1, 0, "R6 hash errored");
        fill_random(60); run(0, 1, 1, 4'b1111, 0, 0, "R4 rx_en low");
        fill_random(60); run(0, 1, 0, 4'b1011, 1, 0, "R5 addr1 disabled");
        fill_random(60); run(0, 0, 1, 4'b0111, 1, 0, "R5 hash disabled");
        build_arp(1);    run(1, 0, 0, 4'b0010, 1, 0, "R7 arp errored");
        build_arp(0);    run(0, 0, 0, 4'b0010, 1, 0, "R7 arp wrong ip");
        build_arp(1); fr[21] = 8'h02; run(0, 0, 0, 4'b0010, 1, 0, "R7 arp reply");
        build_arp(1);    run(0, 0, 0, 4'b1101, 1, 0, "R5 arp disabled");
        build_magic(6, -1); run(0, 1, 0, 4'b0001, 1, 0, "R8 magic six sync");
        build_magic(9, -1); run(0, 1, 0, 4'b0001, 1, 1, "R8 magic long sync gaps");
        build_magic(5, -1); run(0, 1, 0, 4'b0001, 1, 0, "R8 five sync bytes");
        build_magic(6, -1); run(1, 1, 0, 4'b0001, 1, 0, "R9 magic errored");
        build_magic(6, -1); run(0, 0, 0, 4'b0001, 1, 0, "R9 magic no addr1");
        build_magic(6, 40); run(0, 1, 0, 4'b0001, 1, 0, "R10 broken copy");

        // R10: broken attempt followed by a complete sequence in the same frame.
        fill_random(150);
        for (int i = 0; i < 6; i++) fr[14+i] = 8'hFF;
        for (int j = 0; j < 20; j++) fr[20+j] = mb(j % 6);
        fr[40] = 8'h00;
        for (int i = 0; i < 6; i++) fr[41+i] = 8'hFF;
        for (int j = 0; j < 96; j++) fr[47+j] = mb(j % 6);
        run(0, 1, 0, 4'b0001, 1, 0, "R10 retry succeeds");

        // R8: sequence ending on the final byte.
        fill_random(14 + 6 + 96);
        for (int i = 0; i < 6; i++) fr[14+i] = 8'hFF;
        for (int j = 0; j < 96; j++) fr[20+j] = mb(j % 6);
        run(0, 1, 0, 4'b0001, 1, 0, "R8 ends on last byte");

        // R3: second event while the first pulse is still high.
        fill_random(40); send(0, 1, 0, 4'b0100, 1, 0);
        check(wake, 1'b1, "R3 first pulse");
        repeat (5) @(negedge clk);
        fill_random(20); send(0, 0, 1, 4'b1000, 1, 0);
        expect_pulse(1'b1, "R3 restart");

        // R11: beats without end-of-frame, and an idle end-of-frame, never start a pulse.
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            rx_valid = 1; rx_sof = (i == 0); rx_eof = 0; rx_data = 8'($urandom);
            addr1_hit = 1; hash_hit = 1; ev_en = 4'hF; rx_en = 1;
        end
        @(negedge clk);
        rx_valid = 0; rx_eof = 1;
        @(negedge clk);
        check(wake, 1'b0, "R11 no eof beat");
        rx_eof = 0; addr1_hit = 0; hash_hit = 0;
        repeat (3) @(negedge clk);
        check(wake, 1'b0, "R11 idle eof");

        for (int t = 0; t < 40; t++) begin
            int kind = $urandom_range(0, 4);
            case (kind)
                0: build_magic(6 + $urandom_range(0, 3), -1);
                1: build_magic(6, $urandom_range(0, 95));
                2: build_arp(1);
                3: build_arp(0);
                default: fill_random($urandom_range(20, 100));
            endcase
            run($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
                4'($urandom_range(0, 15)), $urandom_range(0, 3) != 0, $urandom_range(0, 1),
                "R5 R7 R8 R9 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule